// File: doc/BRIEF.md
# DMA Channel Enable and Error-Interrupt Control Registers

This block keeps two per-channel bitmaps for a 16-channel DMA engine: one that decides which channels may pass their hardware transfer requests on to the engine, and one that decides which channels may raise an error interrupt. Software reaches both over a small register bus made of an address, a write strobe, byte strobes, write data and combinational read data. A bitmap can be written as a whole word. A single channel, or every channel at once, can also be set or cleared by a byte written to an alias word, so that no read-modify-write sequence is needed.

Per-channel error flags arrive from the transfer engine. Clearing them is the engine's job. Each flag is masked by its channel's error-interrupt enable. The masked flags are OR-reduced and registered into one interrupt line for the interrupt controller. Raw per-channel requests are masked combinationally by the request-enable bitmap.

Top module: `dma_chan_enable_regs`

## Requirements
- R1: After reset, both bitmaps read as zero and `err_irq` is low.
- R2: A write to word offset 0x0C loads the request-enable bitmap. Data bits 7:0 are loaded when `wr_be[0]` is set, and bits 15:8 when `wr_be[1]` is set. A read at 0x0C returns the bitmap in bits 15:0.
- R3: A write to offset 0x14 loads the error-interrupt-enable bitmap, using the same byte-strobe rule as R2. In both bitmap words, bits 31:16 read as zero and ignore writes.
- R4: The alias word at offset 0x18 carries four command bytes, one per byte lane. Lane 0 clears an error-interrupt enable, lane 1 sets one, lane 2 clears a request enable and lane 3 sets one. A lane acts only when its strobe is set. Within a command byte, bits 3:0 name the channel and bit 6 selects all channels. Bits 5, 4 and 7 are ignored. A single-channel command changes only the channel it names.
- R5: When one alias write carries both a clear and a set for the same bitmap, the clear is applied first, so a channel named by both ends up set.
- R6: The alias word reads as zero. Unmapped offsets read as zero and writes to them change nothing.
- R7: `dma_req_out[n]` equals `dma_req_in[n]` AND request-enable bit n, with no clock delay.
- R8: `err_irq` is high in the cycle after any channel has both its error flag and its error-interrupt enable set, and low otherwise.
- R9: A cycle with no write, or a write with all byte strobes clear, leaves both bitmaps unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | 8 | Byte address within the block (word aligned) |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte-lane strobes for the write |
| rd_data | output | 32 | Combinational read data for `addr` |
| dma_req_in | input | 16 | Raw per-channel transfer requests |
| dma_req_out | output | 16 | Requests masked by the request-enable bitmap |
| err_flag | input | 16 | Per-channel error indicators |
| err_irq | output | 1 | Registered combined error interrupt request |

## Verification
The bench targets the all-channels bit combined with a channel number. A design that gave the number priority over this bit would change only one channel. It also issues a clear and a set of the same channel in a single write; reversing the order inside the alias decode would leave that channel cleared. Partial byte strobes and writes into the reserved upper half check that a word write cannot leak into neighbouring lanes or produce nonzero upper read bits. The interrupt is sampled exactly one cycle after flags and enables line up, so an unregistered or two-stage output would miss the check.

// File: rtl/dma_chan_enable_regs.sv
`timescale 1ns/1ps
module dma_chan_enable_regs #(
  parameter int NCH       = 16,
  parameter int AW        = 8,
  parameter int DW        = 32,
  parameter logic [AW-1:0] OFS_REQ   = 8'h0C,
  parameter logic [AW-1:0] OFS_ERR   = 8'h14,
  parameter logic [AW-1:0] OFS_ALIAS = 8'h18
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [DW/8-1:0] wr_be,
  output logic [DW-1:0]   rd_data,
  input  logic [NCH-1:0]  dma_req_in,
  output logic [NCH-1:0]  dma_req_out,
  input  logic [NCH-1:0]  err_flag,
  output logic            err_irq
);
  localparam int NLANE = DW / 8;
  localparam int ALL_BIT = 6;

  logic [NCH-1:0] req_en, err_en, req_nx, err_nx;
  logic hit_req, hit_err, hit_alias;

  assign hit_req   = addr[AW-1:2] == OFS_REQ[AW-1:2];
  assign hit_err   = addr[AW-1:2] == OFS_ERR[AW-1:2];
  assign hit_alias = addr[AW-1:2] == OFS_ALIAS[AW-1:2];

  function automatic logic [NCH-1:0] cmd_mask(input logic [7:0] cmd);
    logic [NCH-1:0] one;
    one = '0;
    one[0] = 1'b1;
    if (cmd[ALL_BIT]) return '1;
    return one << cmd[3:0];
  endfunction

  always_comb begin
    req_nx = req_en;
    err_nx = err_en;
    if (wr_en && hit_req)
      for (int i = 0; i < NCH; i++)
        if (wr_be[i/8]) req_nx[i] = wr_data[i];
    if (wr_en && hit_err)
      for (int i = 0; i < NCH; i++)
        if (wr_be[i/8]) err_nx[i] = wr_data[i];
    if (wr_en && hit_alias) begin
      if (wr_be[0]) err_nx = err_nx & ~cmd_mask(wr_data[7:0]);
      if (wr_be[1]) err_nx = err_nx |  cmd_mask(wr_data[15:8]);
      if (wr_be[2]) req_nx = req_nx & ~cmd_mask(wr_data[23:16]);
      if (wr_be[3]) req_nx = req_nx |  cmd_mask(wr_data[31:24]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_en  <= '0;
      err_en  <= '0;
      err_irq <= 1'b0;
    end else begin
      req_en  <= req_nx;
      err_en  <= err_nx;
      err_irq <= |(err_flag & err_en);
    end
  end

  always_comb begin
    rd_data = '0;
    if (hit_req)      rd_data[NCH-1:0] = req_en;
    else if (hit_err) rd_data[NCH-1:0] = err_en;
  end

  assign dma_req_out = dma_req_in & req_en;

  // R3
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DW-1:NCH] == '0);

  // R4
  single_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_alias && wr_be == 4'b0010 && !wr_data[8+ALL_BIT])
    |=> (err_en[$past(wr_data[11:8])] &&
         $countones(err_en ^ $past(err_en)) <= 1));

  // R4
  single_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_alias && wr_be == 4'b0100 && !wr_data[16+ALL_BIT])
    |=> (!req_en[$past(wr_data[19:16])] &&
         $countones(req_en ^ $past(req_en)) <= 1));

  // R7
  req_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req_out & ~dma_req_in) == '0);

  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_irq) |-> $past(|err_flag));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || wr_be == '0) |=> ($stable(req_en) && $stable(err_en)));
endmodule

// File: tb/tb_dma_chan_enable_regs.sv
`timescale 1ns/1ps
module tb_dma_chan_enable_regs;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [7:0] addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic [3:0] wr_be = 0;
  logic [15:0] dma_req_in = 0, dma_req_out, err_flag = 0;
  logic err_irq;
  int total = 0, bad = 0;
  logic [15:0] req_m = 0, err_m = 0;
  logic exp_irq = 0;

  dma_chan_enable_regs dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .wr_be(wr_be), .rd_data(rd_data), .dma_req_in(dma_req_in),
    .dma_req_out(dma_req_out), .err_flag(err_flag), .err_irq(err_irq));

  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] amask(input logic [7:0] c);
    return c[6] ? 16'hFFFF : (16'h0001 << c[3:0]);
  endfunction

  function automatic logic [31:0] read_model(input logic [7:0] a);
    case (a)
      8'h0C: return {16'h0, req_m};
      8'h14: return {16'h0, err_m};
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    if (a == 8'h0C) begin
      if (be[0]) req_m[7:0] = d[7:0];
      if (be[1]) req_m[15:8] = d[15:8];
    end else if (a == 8'h14) begin
      if (be[0]) err_m[7:0] = d[7:0];
      if (be[1]) err_m[15:8] = d[15:8];
    end else if (a == 8'h18) begin
      if (be[0]) err_m &= ~amask(d[7:0]);
      if (be[1]) err_m |= amask(d[15:8]);
      if (be[2]) req_m &= ~amask(d[23:16]);
      if (be[3]) req_m |= amask(d[31:24]);
    end
  endtask

  // Called at a negedge: drive one cycle, check reads and requests, then the irq.
  task automatic step(input string rtag, input logic we, input logic [7:0] a,
                      input logic [31:0] d, input logic [3:0] be,
                      input logic [15:0] rq, input logic [15:0] fl);
    wr_en = we; addr = a; wr_data = d; wr_be = be; dma_req_in = rq; err_flag = fl;
    #1;
    check(rtag, rd_data, read_model(a));
    check("R7", {16'h0, dma_req_out}, {16'h0, rq & req_m});
    @(negedge clk);
    exp_irq = |(fl & err_m);
    if (we) model_write(a, d, be);
    check("R8", {31'h0, err_irq}, {31'h0, exp_irq});
  endtask

  initial begin
    #(200000 * 8);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] ra;
    int unsigned seed;
    seed = 32'd2024;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    addr = 8'h0C; #1; check("R1", rd_data, 32'h0);
    addr = 8'h14; #1; check("R1", rd_data, 32'h0);
    check("R1", {31'h0, err_irq}, 32'h0);
    rst_n = 1;
    @(negedge clk);
    // R2 full word with upper garbage, R3 reserved bits
    step("R2", 1, 8'h0C, 32'hFFFF_A55A, 4'hF, 16'hFFFF, 0);
    step("R2", 0, 8'h0C, 0, 0, 16'hFFFF, 0);
    step("R3", 1, 8'h14, 32'hDEAD_0F0F, 4'b0010, 0, 0);
    step("R3", 0, 8'h14, 0, 0, 0, 0);
    // R4 single set, all-clear, all-set with channel bits
    step("R4", 1, 8'h18, 32'h0000_0500, 4'b0010, 0, 0);
    step("R4", 0, 8'h14, 0, 0, 0, 0);
    step("R4", 1, 8'h18, 32'h0040_0000, 4'b0100, 0, 0);
    step("R4", 0, 8'h0C, 0, 0, 16'hFFFF, 0);
    step("R4", 1, 8'h18, 32'h4300_0000, 4'b1000, 16'hFFFF, 0);
    step("R4", 0, 8'h0C, 0, 0, 16'h1234, 0);
    step("R4", 1, 8'h18, 32'h00B0_0000, 4'b0100, 16'hFFFF, 0);
    step("R4", 0, 8'h0C, 0, 0, 16'hFFFF, 0);
    // R5 clear then set same channel
    step("R5", 1, 8'h18, 32'h0000_0909, 4'b0011, 0, 0);
    step("R5", 0, 8'h14, 0, 0, 0, 0);
    step("R5", 1, 8'h18, 32'h0C4C_0000, 4'b1100, 0, 0);
    step("R5", 0, 8'h0C, 0, 0, 16'hFFFF, 0);
    // R6 alias and unmapped reads, unmapped write
    step("R6", 1, 8'h1C, 32'hFFFF_FFFF, 4'hF, 0, 0);
    step("R6", 0, 8'h18, 0, 0, 0, 0);
    step("R6", 0, 8'h00, 0, 0, 0, 0);
    // R9 strobes clear
    step("R9", 1, 8'h14, 32'h0, 4'h0, 0, 0);
    step("R9", 0, 8'h14, 0, 0, 0, 0);
    // R8 directed
    step("R8", 1, 8'h14, 32'h0000_0001, 4'h3, 0, 16'hFFFE);
    step("R8", 0, 8'h14, 0, 0, 0, 16'h0001);
    step("R8", 0, 8'h14, 0, 0, 0, 16'h0000);
    // random
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] d;
      logic [3:0] be;
      case ($urandom % 5)
        0: ra = 8'h0C; 1: ra = 8'h14; 2, 3: ra = 8'h18; default: ra = 8'h20;
      endcase
      d = $urandom;
      if ($urandom % 8 != 0) d &= 32'hBFBF_BFBF;
      be = $urandom;
      step(ra == 8'h18 ? "R4" : (ra == 8'h20 ? "R6" : "R2"),
           ($urandom % 4) != 0, ra, d, be, $urandom, $urandom & $urandom);
    end
    step("R9", 0, 8'h0C, 0, 0, 16'hFFFF, 0);
    step("R9", 0, 8'h14, 0, 0, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule